// File: doc/BRIEF.md
# Six-Source Interrupt Controller with Return-Stack Gating

This block gathers interrupt requests from six on-chip sources (two external pins, two timer/event counter overflows, a time-base tick and a real-time-clock tick). It latches each request in a flag and holds a per-source enable and a global enable in two byte-wide control registers. When a request is flagged, enabled and allowed, the block signals the core to push its program counter and jump to a fixed vector for that source. Accepting an interrupt drops the global enable, so by default a service routine is not interrupted. Requests that arrive in the meantime are kept as flags.

The return stack of the core is tracked here as a depth counter. Subroutine calls and accepted interrupts push, and returns pop. While the counter shows the stack full, no interrupt is accepted. A wake-up output reports any flagged and enabled source, whatever the global enable, so a halted core can be restarted.

Top module: `irqc_top`

## Requirements
- R1: After reset both control registers read 0, the stack depth is 0 with `stk_empty`=1 and `stk_full`=0, and `irq_take` and `wake` are 0.
- R2: Register at address 0x0B: bit 0 global enable, bits 1..3 enables of sources 0..2, bits 4..6 flags of sources 0..2, bit 7 reads 0. Register at address 0x1E: bits 0..2 enables of sources 3..5, bits 4..6 flags of sources 3..5, bits 3 and 7 read 0. A write replaces all of these fields.
- R3: A 1 on `src_evt[i]` sets flag i on the next edge whatever the enables, and the flag stays set until it is acknowledged or overwritten.
- R4: `irq_take` is 1 in a cycle only when some flag and its enable are 1, the global enable is 1, the stack is not full, and none of `call_push`, `ret`, `ret_ei` is 1.
- R5: Among accepted candidates source 0 has the highest priority and source 5 the lowest. `irq_src` gives the index and `irq_vector` = 0x04 + 4*index.
- R6: On the edge that ends an `irq_take` cycle, the accepted flag clears, the global enable clears and the stack depth rises by one.
- R7: Setting the global enable by a register write inside a service routine lets a further pending, enabled source be taken (nesting).
- R8: While the depth equals the stack size (8), `irq_take` stays 0 and further pushes are ignored. After a pop, acceptance resumes in the next cycle.
- R9: `ret` decrements the depth and leaves the global enable unchanged. `ret_ei` decrements the depth and sets the global enable. A pop at depth 0 leaves the depth at 0.
- R10: `wake` is 1 whenever some flag and its enable are both 1, whatever the global enable.
- R11: A source event in the same cycle as that source's acknowledge, or as a register write that clears its flag, leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 6 | Per-source request pulses |
| reg_wr | input | 1 | Control register write strobe |
| reg_addr | input | 8 | Control register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| call_push | input | 1 | Core pushes a return address (subroutine call) |
| ret | input | 1 | Core pops a return address, global enable kept |
| ret_ei | input | 1 | Core pops a return address and sets the global enable |
| irq_take | output | 1 | Interrupt accepted this cycle: push PC and branch |
| irq_src | output | 3 | Index of the accepted source |
| irq_vector | output | 8 | Branch target for the accepted source |
| wake | output | 1 | Some source is flagged and enabled |
| stk_full | output | 1 | Return stack at its limit |
| stk_empty | output | 1 | Return stack empty |
| stk_depth | output | 4 | Current return stack depth |

## Verification
The hardest state to reach is a pending, enabled request with the global enable set while the stack is full. The stimulus fills the stack with eight calls, raises a flag, and then shows that the request stays refused until a single plain return makes room. A second hard case is an event that coincides with its own acknowledge or with a register write that clears its flag. The bench lines up a register write with the event in the same cycle and a source pulse with the take cycle, then reads the flag back through the register port.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int IRQ_SRCS    = 6;
  localparam int IDX_W       = $clog2(IRQ_SRCS);
  localparam int REG_W       = 8;
  localparam int SRC_PER_REG = (IRQ_SRCS + 1) / 2;
  localparam int EMI_POS     = 0;
  localparam int EN_LO_A     = 1;
  localparam int EN_LO_B     = 0;
  localparam int FLAG_LO     = 4;

  typedef logic [IRQ_SRCS-1:0] src_vec_t;
  typedef logic [IDX_W-1:0]    src_idx_t;
endpackage

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int            AW     = 8,
  parameter logic [AW-1:0] ADDR_A = 8'h0B,
  parameter logic [AW-1:0] ADDR_B = 8'h1E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  src_vec_t         src_evt,
  input  src_vec_t         ack,
  input  logic             ret_ei,
  output logic             emi,
  output src_vec_t         en,
  output src_vec_t         flags,
  output logic [REG_W-1:0] reg_rdata
);

  logic     emi_q, emi_n;
  src_vec_t en_q, en_n;
  src_vec_t fl_q, fl_n;
  logic     upd;
  logic     hit_a, hit_b;

  assign hit_a = (reg_addr == ADDR_A);
  assign hit_b = (reg_addr == ADDR_B);
  assign upd   = reg_wr | ret_ei | (|ack) | (|src_evt);

  // next-state: write, then return-with-enable, then acknowledge, then events
  always_comb begin
    emi_n = emi_q;
    en_n  = en_q;
    fl_n  = fl_q;
    if (reg_wr && hit_a) begin
      emi_n = reg_wdata[EMI_POS];
      for (int i = 0; i < SRC_PER_REG; i++) begin
        en_n[i] = reg_wdata[EN_LO_A + i];
        fl_n[i] = reg_wdata[FLAG_LO + i];
      end
    end
    if (reg_wr && hit_b) begin
      for (int i = SRC_PER_REG; i < IRQ_SRCS; i++) begin
        en_n[i] = reg_wdata[EN_LO_B + i - SRC_PER_REG];
        fl_n[i] = reg_wdata[FLAG_LO + i - SRC_PER_REG];
      end
    end
    if (ret_ei) emi_n = 1'b1;
    if (|ack)   emi_n = 1'b0;
    fl_n = (fl_n & ~ack) | src_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emi_q <= 1'b0;
      en_q  <= '0;
      fl_q  <= '0;
    end else if (upd) begin
      emi_q <= emi_n;
      en_q  <= en_n;
      fl_q  <= fl_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_a) begin
      reg_rdata[EMI_POS] = emi_q;
      for (int i = 0; i < SRC_PER_REG; i++) begin
        reg_rdata[EN_LO_A + i] = en_q[i];
        reg_rdata[FLAG_LO + i] = fl_q[i];
      end
    end else if (hit_b) begin
      for (int i = SRC_PER_REG; i < IRQ_SRCS; i++) begin
        reg_rdata[EN_LO_B + i - SRC_PER_REG] = en_q[i];
        reg_rdata[FLAG_LO + i - SRC_PER_REG] = fl_q[i];
      end
    end
  end

  assign emi   = emi_q;
  assign en    = en_q;
  assign flags = fl_q;

endmodule

// File: rtl/irqc_arb.sv
`timescale 1ns/1ps
module irqc_arb
  import irqc_pkg::*;
#(
  parameter int            VW       = 8,
  parameter logic [VW-1:0] VEC_BASE = 8'h04,
  parameter logic [VW-1:0] VEC_STEP = 8'h04
) (
  input  src_vec_t        pending,
  input  logic            allow,
  output src_vec_t        ack,
  output logic            take,
  output src_idx_t        idx,
  output logic [VW-1:0]   vector
);

  logic [IRQ_SRCS:0] higher;
  src_vec_t          grant;

  assign higher[0] = 1'b0;

  // lower index wins: each source is masked by any pending source below it
  for (genvar g = 0; g < IRQ_SRCS; g++) begin : g_prio
    assign grant[g]    = pending[g] & ~higher[g];
    assign higher[g+1] = higher[g] | pending[g];
  end

  assign take = allow & higher[IRQ_SRCS];
  assign ack  = grant & {IRQ_SRCS{allow}};

  always_comb begin
    idx = '0;
    for (int i = 0; i < IRQ_SRCS; i++) begin
      if (grant[i]) idx = src_idx_t'(i);
    end
  end

  assign vector = VEC_BASE + VW'(idx) * VEC_STEP;

endmodule

// File: rtl/irqc_stack.sv
`timescale 1ns/1ps
module irqc_stack #(
  parameter int DEPTH = 8,
  parameter int DW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [DW-1:0] depth,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] depth_q, depth_n;
  logic          do_push, do_pop, upd;

  assign full    = (depth_q == DW'(DEPTH));
  assign empty   = (depth_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign upd     = do_push ^ do_pop;

  always_comb begin
    depth_n = depth_q;
    if (do_push && !do_pop) depth_n = depth_q + DW'(1);
    if (do_pop && !do_push) depth_n = depth_q - DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   depth_q <= '0;
    else if (upd) depth_q <= depth_n;
  end

  assign depth = depth_q;

endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
  import irqc_pkg::*;
#(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] ADDR_A    = 8'h0B,
  parameter logic [AW-1:0] ADDR_B    = 8'h1E,
  parameter int            STK_DEPTH = 8,
  parameter int            VW        = 8,
  parameter logic [VW-1:0] VEC_BASE  = 8'h04,
  parameter logic [VW-1:0] VEC_STEP  = 8'h04,
  parameter int            SDW       = $clog2(STK_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IRQ_SRCS-1:0] src_evt,
  input  logic                reg_wr,
  input  logic [AW-1:0]       reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                call_push,
  input  logic                ret,
  input  logic                ret_ei,
  output logic                irq_take,
  output logic [IDX_W-1:0]    irq_src,
  output logic [VW-1:0]       irq_vector,
  output logic                wake,
  output logic                stk_full,
  output logic                stk_empty,
  output logic [SDW-1:0]      stk_depth
);

  logic [1:0] rst_pipe;
  logic       rst_ni;
  logic       emi_w;
  src_vec_t   en_w, flag_w, ack_w, pend_w;
  logic       allow_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  irqc_regs #(.AW(AW), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)) u_regs (
    .clk       (clk),
    .rst_n     (rst_ni),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .src_evt   (src_evt),
    .ack       (ack_w),
    .ret_ei    (ret_ei),
    .emi       (emi_w),
    .en        (en_w),
    .flags     (flag_w),
    .reg_rdata (reg_rdata)
  );

  assign pend_w  = flag_w & en_w & {IRQ_SRCS{emi_w}};
  assign allow_w = ~stk_full & ~call_push & ~ret & ~ret_ei;

  irqc_arb #(.VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
    .pending (pend_w),
    .allow   (allow_w),
    .ack     (ack_w),
    .take    (irq_take),
    .idx     (irq_src),
    .vector  (irq_vector)
  );

  irqc_stack #(.DEPTH(STK_DEPTH), .DW(SDW)) u_stack (
    .clk   (clk),
    .rst_n (rst_ni),
    .push  (irq_take | call_push),
    .pop   (ret | ret_ei),
    .depth (stk_depth),
    .full  (stk_full),
    .empty (stk_empty)
  );

  assign wake = |(flag_w & en_w);

endmodule

// File: rtl/irqc_chk.sv
`timescale 1ns/1ps
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int STK_DEPTH = 8,
  parameter int SDW       = $clog2(STK_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_take,
  input logic           stk_full,
  input logic [SDW-1:0] stk_depth,
  input logic           ret_ei,
  input logic           emi,
  input src_vec_t       ack,
  input src_vec_t       flags,
  input src_vec_t       src_evt
);

  AST_TAKE_NEEDS_EMI: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> emi); // R4

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack)); // R5

  AST_TAKE_CLEARS_EMI: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !emi); // R6

  AST_TAKE_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> stk_depth == ($past(stk_depth) + SDW'(1))); // R6

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !irq_take); // R8

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= SDW'(STK_DEPTH)); // R8

  AST_RETI_SETS_EMI: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ei |=> emi); // R9

  for (genvar g = 0; g < IRQ_SRCS; g++) begin : g_evt
    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      src_evt[g] |=> flags[g]); // R11
  end

endmodule

bind irqc_top irqc_chk #(.STK_DEPTH(STK_DEPTH), .SDW(SDW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_ni),
  .irq_take  (irq_take),
  .stk_full  (stk_full),
  .stk_depth (stk_depth),
  .ret_ei    (ret_ei),
  .emi       (emi_w),
  .ack       (ack_w),
  .flags     (flag_w),
  .src_evt   (src_evt)
);

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] src_evt;
  logic       reg_wr;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       call_push, ret, ret_ei;
  logic       irq_take;
  logic [2:0] irq_src;
  logic [7:0] irq_vector;
  logic       wake, stk_full, stk_empty;
  logic [3:0] stk_depth;

  int total = 0;
  int bad   = 0;
  int exp_q[$];
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .call_push(call_push), .ret(ret), .ret_ei(ret_ei),
    .irq_take(irq_take), .irq_src(irq_src), .irq_vector(irq_vector),
    .wake(wake), .stk_full(stk_full), .stk_empty(stk_empty),
    .stk_depth(stk_depth)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(string req, logic [7:0] a, int exp);
    reg_addr = a;
    #1;
    chk(req, $sformatf("reg[%0h]", a), reg_rdata, exp);
  endtask

  task automatic pulse(logic [5:0] v);
    src_evt = v;
    cyc();
    src_evt = '0;
  endtask

  // scoreboard monitor: every accepted interrupt must match the next expected source
  always begin
    @(negedge clk);
    #1.5;
    if (rst_n && irq_take) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R4 unexpected take act=src%0d exp=none", irq_src);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (irq_src != 3'(e) || irq_vector != 8'(4 + 4 * e)) begin
          bad++;
          $display("FAIL R5 take act=src%0d/0x%0h exp=src%0d/0x%0h",
                   irq_src, irq_vector, e, 4 + 4 * e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_evt = '0; reg_wr = 1'b0; reg_addr = 8'h0B; reg_wdata = '0;
    call_push = 1'b0; ret = 1'b0; ret_ei = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1 reset state
    rd("R1", 8'h0B, 8'h00);
    rd("R1", 8'h1E, 8'h00);
    chk("R1", "empty", stk_empty, 1);
    chk("R1", "full", stk_full, 0);
    chk("R1", "depth", stk_depth, 0);
    chk("R1", "take", irq_take, 0);
    chk("R1", "wake", wake, 0);

    // R2 layout and unused bits
    wr(8'h0B, 8'hFE); rd("R2", 8'h0B, 8'h7E);
    wr(8'h1E, 8'h8F); rd("R2", 8'h1E, 8'h07);
    wr(8'h0B, 8'h0E); rd("R2", 8'h0B, 8'h0E);

    // R3 / R10 / R4: flags latch with global enable off, no take
    pulse(6'b000100);
    rd("R3", 8'h0B, 8'h4E);
    chk("R10", "wake", wake, 1);
    chk("R4", "take emi off", irq_take, 0);
    pulse(6'b100000);
    rd("R3", 8'h1E, 8'h47);
    wr(8'h1E, 8'h00);
    wr(8'h0B, 8'h40);
    #1 chk("R10", "wake enable off", wake, 0);

    // R6: enable globally, take src2
    exp_q.push_back(2);
    wr(8'h0B, 8'h4F);
    #1 chk("R4", "take", irq_take, 1);
    cyc();
    rd("R6", 8'h0B, 8'h0E);
    chk("R6", "depth", stk_depth, 1);

    // R7 nesting by software
    exp_q.push_back(0);
    wr(8'h0B, 8'h13);
    #1 chk("R7", "nested take", irq_take, 1);
    cyc();
    rd("R7", 8'h0B, 8'h02);
    chk("R7", "depth", stk_depth, 2);

    // R5 priority order via return-with-enable
    wr(8'h0B, 8'h0E);
    wr(8'h1E, 8'h07);
    pulse(6'h3F);
    rd("R3", 8'h0B, 8'h7E);
    rd("R3", 8'h1E, 8'h77);
    for (int k = 0; k < 6; k++) begin
      exp_q.push_back(k);
      ret_ei = 1'b1;
      cyc();
      ret_ei = 1'b0;
      #1 chk("R5", $sformatf("src order %0d", k), irq_src, k);
      cyc();
    end
    rd("R5", 8'h0B, 8'h0E);
    rd("R5", 8'h1E, 8'h07);
    chk("R10", "wake cleared", wake, 0);
    chk("R6", "depth", stk_depth, 2);

    // R9 returns
    ret = 1'b1; cyc(); ret = 1'b0;
    chk("R9", "depth ret", stk_depth, 1);
    rd("R9", 8'h0B, 8'h0E);
    ret_ei = 1'b1; cyc(); ret_ei = 1'b0;
    chk("R9", "depth reti", stk_depth, 0);
    rd("R9", 8'h0B, 8'h0F);
    ret = 1'b1; cyc(); ret = 1'b0;
    chk("R9", "pop empty", stk_depth, 0);
    chk("R9", "empty", stk_empty, 1);

    // R8 stack full gating
    call_push = 1'b1; repeat (8) cyc();
    chk("R8", "depth full", stk_depth, 8);
    chk("R8", "full", stk_full, 1);
    cyc(); call_push = 1'b0;
    chk("R8", "push ignored", stk_depth, 8);
    pulse(6'b000010);
    rd("R8", 8'h0B, 8'h2F);
    for (int k = 0; k < 3; k++) begin
      #1 chk("R8", "take while full", irq_take, 0);
      cyc();
    end
    chk("R10", "wake while full", wake, 1);
    exp_q.push_back(1);
    ret = 1'b1; cyc(); ret = 1'b0;
    chk("R8", "depth after pop", stk_depth, 7);
    #1 chk("R8", "take resumes", irq_take, 1);
    cyc();
    chk("R8", "full again", stk_full, 1);
    rd("R6", 8'h0B, 8'h0E);

    // R11 event coincident with acknowledge
    ret = 1'b1; repeat (2) cyc(); ret = 1'b0;
    exp_q.push_back(0);
    wr(8'h0B, 8'h13);
    src_evt = 6'b000001;
    #1 chk("R11", "take", irq_take, 1);
    cyc();
    src_evt = '0;
    rd("R11", 8'h0B, 8'h12);
    chk("R11", "depth", stk_depth, 7);
    // R11 event coincident with clearing write
    wr(8'h0B, 8'h02);
    rd("R11", 8'h0B, 8'h02);
    src_evt = 6'b000001;
    wr(8'h0B, 8'h02);
    src_evt = '0;
    rd("R11", 8'h0B, 8'h12);

    cyc();
    chk("R5", "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule